// File: doc/BRIEF.md
# Write-instruction clock length gate

This block guards the programming path of a serial memory that accepts framed instructions on a select, clock and data line. While select is high it counts the rising edges of the serial clock, beginning with the edge that samples the start bit. When select falls, it compares that count with the exact frame length of the instruction class that the upstream decoder presented. For the five classes that change stored state it then issues a one-cycle commit pulse if the lengths agree, or a one-cycle abort pulse if they differ.

A clock pulse that is missing or extra shifts every later bit in the frame. The gate turns such a misaligned write into a harmless abort instead of corrupting a word. Serial clock edges arrive as a single-cycle strobe in the system clock domain. The header length is one start bit, two op-code bits and `ADDR_W` address bits, which is 11 clocks at the default of 8.

Top module: `wr_len_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `commit` and `abort` are both low.
- R2: Strobes sampled with `din` low before the start bit are not counted. Counting begins with the first strobe that sees `din` high while `sel` is high.
- R3: For class 1 (single word write), the expected length is 3+ADDR_W+16 edges (27 at the default). An exact match gives `commit` in the cycle after the one in which `sel` is first seen low.
- R4: For class 1, a count one edge short or one edge long gives `abort` in that same cycle, and no `commit`.
- R5: For class 3 (fill whole array), the expected length is the same as for class 1.
- R6: For classes 4 (boundary register write) and 5 (boundary register clear), the expected length is the header alone, 3+ADDR_W edges.
- R7: For class 2 (page write), the gate commits only if `page_words` is between 1 and 4 and the count equals 3+ADDR_W+16×`page_words`. Any other count or word number aborts.
- R8: Classes 0, 6 and 7 never produce `commit` or `abort`.
- R9: The edge counter saturates at its maximum (127 at the default), so a burst of 155 edges on a class 1 frame aborts instead of wrapping to 27.
- R10: `commit` and `abort` are never high together, each lasts exactly one cycle, and exactly one pulse follows each fall of `sel` for a write-class frame.
- R11: A strobe in any cycle in which `sel` is low, including the cycle of its fall, is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select level, synchronous to `clk` |
| sck_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| din | input | 1 | Serial data level at the strobe |
| op_class | input | 3 | Decoded class: 0 none, 1 write, 2 page write, 3 fill, 4 boundary write, 5 boundary clear, 6/7 other |
| page_words | input | 3 | Data words received in a page write |
| commit | output | 1 | Start-programming pulse |
| abort | output | 1 | Cancel pulse |

## Verification
A serial clock strobe can arrive in the same system cycle in which select is first seen low, so edge counting and the end-of-frame decision meet in one cycle. The bench drives a strobe together with the fall of select on a correct-length frame and on a frame one edge short. It judges the design right only if the first frame still commits and the second still aborts, which shows that the coincident edge was left out of the decision.

// File: rtl/wr_len_gate.sv
module wr_len_gate #(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_rise,
  input  logic       din,
  input  logic [2:0] op_class,
  input  logic [2:0] page_words,
  output logic       commit,
  output logic       abort
);
  localparam int HDR_LEN = 3 + ADDR_W;
  localparam int LONGEST = HDR_LEN + WORD_W * MAX_WORDS;
  localparam int CNT_W   = $clog2(LONGEST + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LEN_HDR  = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(HDR_LEN + WORD_W);

  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_PAGE  = 3'd2;
  localparam logic [2:0] OP_FILL  = 3'd3;
  localparam logic [2:0] OP_BWR   = 3'd4;
  localparam logic [2:0] OP_BCLR  = 3'd5;

  logic             sel_q;
  logic             started;
  logic [CNT_W-1:0] cnt;
  logic             want;
  logic             len_ok;
  logic             fall;
  logic             pw_ok;

  assign fall  = sel_q & ~sel;
  assign pw_ok = (page_words != 3'd0) && (int'(page_words) <= MAX_WORDS);

  always_comb begin
    want   = 1'b0;
    len_ok = 1'b0;
    case (op_class)
      OP_WRITE, OP_FILL: begin
        want   = 1'b1;
        len_ok = (cnt == LEN_WORD);
      end
      OP_PAGE: begin
        want   = 1'b1;
        len_ok = pw_ok &&
                 (cnt == LEN_HDR + CNT_W'(page_words) * CNT_W'(WORD_W));
      end
      OP_BWR, OP_BCLR: begin
        want   = 1'b1;
        len_ok = (cnt == LEN_HDR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      started <= 1'b0;
      cnt     <= '0;
      commit  <= 1'b0;
      abort   <= 1'b0;
    end else begin
      sel_q  <= sel;
      commit <= fall & want & len_ok;
      abort  <= fall & want & ~len_ok;
      if (!sel) begin
        cnt     <= '0;
        started <= 1'b0;
      end else if (sck_rise && (started || din)) begin
        started <= 1'b1;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));

  p_commit_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_abort_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  p_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> ($past(sel, 2) && !$past(sel, 1)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> ($past(op_class) != 3'd0 && $past(op_class) < 3'd6));

  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cnt == CNT_MAX) |=> (!sel || cnt == CNT_MAX));

  p_low_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));
endmodule

// File: tb/test_wr_len_gate.sv
`timescale 1ns/1ps
module test_wr_len_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       sck_rise = 1'b0;
  logic       din = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [2:0] page_words = 3'd0;
  logic       commit;
  logic       abort;

  int vectors = 0;
  int errs = 0;
  bit done = 0;

  localparam int AW = 8;
  localparam int HDR = 3 + AW;

  always #4 clk = ~clk;

  wr_len_gate i_wr_len_gate (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .din(din),
    .op_class(op_class), .page_words(page_words),
    .commit(commit), .abort(abort)
  );

  function automatic int expect_of(input logic [2:0] cls, input int pw, input int n);
    int eff;
    eff = (n > 127) ? 127 : n;
    case (cls)
      3'd1, 3'd3: return (eff == HDR + 16) ? 1 : 2;
      3'd2: return (pw >= 1 && pw <= 4 && eff == HDR + 16 * pw) ? 1 : 2;
      3'd4, 3'd5: return (eff == HDR) ? 1 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int gc, input int ga,
                       input int ec, input int ea);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got commit=%0d abort=%0d expected commit=%0d abort=%0d",
               tag, gc, ga, ec, ea);
    end
  endtask

  task automatic strobe(input logic b);
    din = b;
    sck_rise = 1'b1;
    @(negedge clk);
    sck_rise = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input int lead, input int nclk, input logic [2:0] cls,
                           input int pw, input bit edge_at_fall, input string tag);
    int ex, nc, na, ec, ea;
    bit bad;
    ex = expect_of(cls, pw, nclk);
    ec = (ex == 1); ea = (ex == 2);
    @(negedge clk);
    sel = 1'b1; op_class = cls; page_words = 3'(pw); din = 1'b0;
    @(negedge clk);
    for (int i = 0; i < lead; i++) strobe(1'b0);
    for (int i = 0; i < nclk; i++) strobe((i == 0) ? 1'b1 : logic'(i % 3 == 0));
    sel = 1'b0;
    sck_rise = edge_at_fall;
    din = 1'b1;
    nc = 0; na = 0; bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sck_rise = 1'b0;
      if (commit) begin nc++; if (k != 0) bad = 1; end
      if (abort) begin na++; if (k != 0) bad = 1; end
      if (commit && abort) bad = 1;
    end
    check(nc == ec && na == ea && !bad, tag, nc, na, ec, ea);
    op_class = 3'd0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!commit && !abort, "R1 during reset", commit, abort, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!commit && !abort, "R1 after release", commit, abort, 0, 0);
  endtask

  task automatic t_write;
    run_frame(0, 27, 3'd1, 0, 0, "R3 R10 write exact");
    run_frame(0, 26, 3'd1, 0, 0, "R4 write short");
    run_frame(0, 28, 3'd1, 0, 0, "R4 write long");
  endtask

  task automatic t_lead;
    run_frame(5, 27, 3'd1, 0, 0, "R2 leading zeros ignored");
  endtask

  task automatic t_fill_bound;
    run_frame(0, 27, 3'd3, 0, 0, "R5 fill exact");
    run_frame(0, 26, 3'd3, 0, 0, "R5 fill short");
    run_frame(0, 11, 3'd4, 0, 0, "R6 boundary write exact");
    run_frame(0, 11, 3'd5, 0, 0, "R6 boundary clear exact");
    run_frame(0, 12, 3'd5, 0, 0, "R6 boundary clear long");
  endtask

  task automatic t_page;
    run_frame(0, 27, 3'd2, 1, 0, "R7 page one word");
    run_frame(0, 59, 3'd2, 3, 0, "R7 page three words");
    run_frame(0, 75, 3'd2, 4, 0, "R7 page four words");
    run_frame(0, 27, 3'd2, 2, 0, "R7 page count mismatch");
    run_frame(0, 11, 3'd2, 0, 0, "R7 page zero words");
    run_frame(0, 91, 3'd2, 5, 0, "R7 page five words");
  endtask

  task automatic t_other;
    run_frame(0, 27, 3'd6, 0, 0, "R8 class 6 silent");
    run_frame(0, 27, 3'd0, 0, 0, "R8 class 0 silent");
    run_frame(0, 27, 3'd7, 0, 0, "R8 class 7 silent");
  endtask

  task automatic t_sat;
    run_frame(0, 155, 3'd1, 0, 0, "R9 saturating burst");
  endtask

  task automatic t_edge_fall;
    run_frame(0, 27, 3'd1, 0, 1, "R11 edge at fall exact");
    run_frame(0, 26, 3'd1, 0, 1, "R11 edge at fall short");
  endtask

  initial begin
    t_reset();
    t_write();
    t_lead();
    t_fill_bound();
    t_page();
    t_other();
    t_sat();
    t_edge_fall();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      vectors++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule